// File: doc/BRIEF.md
# Dual-Protocol Host Bus Slave Bridge

This block lets an 8-bit host processor reach a chip's internal registers over one of three bus styles. It turns host strobes into a one-request-at-a-time internal handshake and reports completion back to the host. The three styles are a data-strobe bus with a read/write direction level, a bus with separate active-low read and write strobes, and that same separate-strobe bus with address and data sharing the data lines. The host holds off on a wait line or waits for an acknowledge, depending on the style. Every host control input passes through a two-flop synchronizer before the block acts on it. Each access starts on the first synchronized cycle in which both chip select and a strobe are active.

The bus style comes from the address-latch-enable (ALE) pin. A falling ALE edge seen since reset selects the multiplexed style; that choice is sticky until reset, and the 8-bit address is taken from the data lines at that edge. With no such edge, ALE held high selects the data-strobe style and ALE held low selects the separate-strobe style with the two address pins.

The open-drain wait/acknowledge pin and the tri-state data lines appear as output-enable signals. An enable of 1 means the pin is pulled low or driven. The register file behind the handshake lives outside the block.

Top module: `hostbus_bridge`

## Requirements
- R1: While `rst` is high, at the next clock edge `reg_req`, `rdy_oe` and `ad_oe` are 0.
- R2: No access starts unless `cs_n` is low. A strobe with `cs_n` high raises neither `reg_req` nor `rdy_oe`.
- R3: Separate-strobe direct style: `rd_ds_n`=0 requests a read and `wr_rw`=0 requests a write with `reg_wdata` taken from `ad_i`. `reg_addr` is `addr_i` zero-extended. The host keeps address and data stable from the strobe until completion.
- R4: Multiplexed style: `reg_addr` is the `ad_i` value held when ALE falls. `ad_i` must stay at that value for three clock edges after the fall. Later strobes then carry write data or nothing on `ad_i`.
- R5: Bus style selection works as follows. A falling ALE edge since reset selects the multiplexed style. Otherwise ALE=1 selects the data-strobe style, where `wr_rw`=0 alone (data strobe high) starts no access. ALE=0 selects the separate-strobe direct style.
- R6: Data-strobe style: `cs_n`=0 and `rd_ds_n`=0 start an access. `wr_rw`=1 means read and 0 means write.
- R7: Separate-strobe styles: `rdy_oe` is 1 (wait line pulled low) from the cycle `reg_req` rises until the edge on which `reg_done` is seen, where both fall.
- R8: Data-strobe style: `rdy_oe` stays 0 while the request is pending. It rises on the edge on which `reg_done` is seen. It holds until the strobe's release has passed the synchronizer and falls on the third edge after the release.
- R9: On completion of a read, `ad_oe` goes to 1 with `ad_o` equal to `reg_rdata`, until the strobe is released (third edge after release). `ad_oe` stays 0 for writes and while a request is pending.
- R10: `reg_req` holds with a stable `reg_addr` and `reg_we` until `reg_done`. A strobe held active after completion starts no further access.
- R11: `reg_req` rises on the third rising edge counted from the first edge that samples chip select and strobe both active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_ds_n | input | 1 | Read strobe (separate-strobe) or data strobe (data-strobe style), active low |
| wr_rw | input | 1 | Write strobe active low (separate-strobe) or direction level, 1 = read (data-strobe style) |
| ale | input | 1 | Address latch enable; also selects bus style |
| addr_i | input | NM_ADDR_W | Address pins for the direct styles |
| ad_i | input | DATA_W | Data lines in (address too in multiplexed style) |
| ad_o | output | DATA_W | Read data out |
| ad_oe | output | 1 | Drive enable for the data lines |
| rdy_oe | output | 1 | Pull-low enable for the open-drain wait/acknowledge pin |
| reg_req | output | 1 | Internal request, held until `reg_done` |
| reg_we | output | 1 | Internal request is a write |
| reg_addr | output | ADDR_W | Internal register address |
| reg_wdata | output | DATA_W | Internal write data |
| reg_rdata | input | DATA_W | Internal read data, valid with `reg_done` |
| reg_done | input | 1 | Internal completion pulse |

## Verification
The bench builds the block with its defaults: 8-bit data, 8-bit internal address and two direct address pins. This makes the full 256-register space reachable through the multiplexed style, while the direct styles reach only its lowest four registers. The register model behind the handshake takes a latency chosen per access, from zero to six cycles. This shows that the wait line and the acknowledge track completion rather than a fixed delay, and that a zero-latency completion does not cause a second request.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
  typedef enum logic [1:0] {
    BUS_SEP_DIRECT = 2'd0,
    BUS_SEP_MUX    = 2'd1,
    BUS_STROBE_DIR = 2'd2
  } bus_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2
  } acc_state_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_mode_detect.sv
module hb_mode_detect
  import hostbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_s,
  input  logic [DATA_W-1:0] ad_i,
  output bus_mode_e         mode,
  output logic [ADDR_W-1:0] mux_addr
);
  logic ale_q;
  logic mux_seen;
  logic ale_fall;

  assign ale_fall = ale_q && !ale_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q    <= 1'b0;
      mux_seen <= 1'b0;
      mux_addr <= '0;
    end else begin
      ale_q <= ale_s;
      if (ale_fall) begin
        mux_seen <= 1'b1;
        mux_addr <= ad_i[ADDR_W-1:0];
      end
    end
  end

  always_comb begin
    if (mux_seen)   mode = BUS_SEP_MUX;
    else if (ale_s) mode = BUS_STROBE_DIR;
    else            mode = BUS_SEP_DIRECT;
  end
endmodule

// File: rtl/hb_access_fsm.sv
module hb_access_fsm
  import hostbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_mode_e         mode,
  input  logic              cs_s,
  input  logic              rs_s,
  input  logic              wr_s,
  input  logic [ADDR_W-1:0] addr_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              reg_done,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              rdy_oe,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe
);
  acc_state_e state;
  logic act, act_q, strobe_style, strobe_q;

  assign strobe_style = (mode == BUS_STROBE_DIR);
  // Data-strobe style needs the data strobe; separate strobes accept either.
  assign act = !cs_s && (strobe_style ? !rs_s : (!rs_s || !wr_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      act_q     <= 1'b0;
      strobe_q  <= 1'b0;
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      rdy_oe    <= 1'b0;
      ad_o      <= '0;
      ad_oe     <= 1'b0;
    end else begin
      act_q <= act;
      case (state)
        ST_IDLE: begin
          if (act && !act_q) begin
            state     <= ST_WAIT;
            reg_req   <= 1'b1;
            // Low on the shared pin means write in every style.
            reg_we    <= !wr_s;
            reg_addr  <= addr_sel;
            reg_wdata <= wdata;
            strobe_q  <= strobe_style;
            rdy_oe    <= !strobe_style;
          end
        end
        ST_WAIT: begin
          if (reg_done) begin
            state   <= ST_HOLD;
            reg_req <= 1'b0;
            rdy_oe  <= strobe_q;
            if (!reg_we) begin
              ad_o  <= reg_rdata;
              ad_oe <= 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (!act) begin
            state  <= ST_IDLE;
            rdy_oe <= 1'b0;
            ad_oe  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hostbus_bridge.sv
module hostbus_bridge
  import hostbus_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int NM_ADDR_W = 2,
  parameter int SYNC_STG  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 rd_ds_n,
  input  logic                 wr_rw,
  input  logic                 ale,
  input  logic [NM_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]    ad_i,
  output logic [DATA_W-1:0]    ad_o,
  output logic                 ad_oe,
  output logic                 rdy_oe,
  output logic                 reg_req,
  output logic                 reg_we,
  output logic [ADDR_W-1:0]    reg_addr,
  output logic [DATA_W-1:0]    reg_wdata,
  input  logic [DATA_W-1:0]    reg_rdata,
  input  logic                 reg_done
);
  localparam int CTL_W = 4;

  logic [CTL_W-1:0] ctl_s;
  bus_mode_e        mode;
  logic [ADDR_W-1:0] mux_addr, addr_sel;

  hb_sync #(.W(CTL_W), .STAGES(SYNC_STG), .RST_VAL(4'b1110)) sync_i (
    .clk(clk), .rst(rst),
    .d({cs_n, rd_ds_n, wr_rw, ale}),
    .q(ctl_s)
  );

  hb_mode_detect #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mode_i (
    .clk(clk), .rst(rst), .ale_s(ctl_s[0]), .ad_i(ad_i),
    .mode(mode), .mux_addr(mux_addr)
  );

  assign addr_sel = (mode == BUS_SEP_MUX) ? mux_addr : ADDR_W'(addr_i);

  hb_access_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) fsm_i (
    .clk(clk), .rst(rst), .mode(mode),
    .cs_s(ctl_s[3]), .rs_s(ctl_s[2]), .wr_s(ctl_s[1]),
    .addr_sel(addr_sel), .wdata(ad_i),
    .reg_done(reg_done), .reg_rdata(reg_rdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rdy_oe(rdy_oe), .ad_o(ad_o), .ad_oe(ad_oe)
  );
endmodule

// File: rtl/hostbus_bridge_chk.sv
module hostbus_bridge_chk #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int NM_ADDR_W = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cs_n,
  input logic                 ad_oe,
  input logic                 rdy_oe,
  input logic                 reg_req,
  input logic                 reg_we,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic                 reg_done
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!reg_req && !rdy_oe && !ad_oe));

  a_r10_req_held: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_done) |=> reg_req);

  a_r10_req_stable: assert property (@(posedge clk) disable iff (rst)
    (reg_req && $past(reg_req)) |-> ($stable(reg_addr) && $stable(reg_we)));

  a_r2_cs_gates: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_req) |-> !$past(cs_n, 2));

  a_r9_no_drive_pending: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> !reg_req);

  a_r9_drive_reads_only: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> !reg_we);
endmodule

bind hostbus_bridge hostbus_bridge_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NM_ADDR_W(NM_ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .cs_n(cs_n), .ad_oe(ad_oe), .rdy_oe(rdy_oe),
  .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_done(reg_done)
);

// File: tb/hostbus_bridge_tb_top.sv
module hostbus_bridge_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_ds_n = 1'b1, wr_rw = 1'b1, ale = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] ad_i = '0;
  logic [7:0] ad_o, reg_addr, reg_wdata;
  logic [7:0] reg_rdata = '0;
  logic ad_oe, rdy_oe, reg_req, reg_we;
  logic reg_done = 1'b0;

  int checks = 0;
  int failures = 0;
  int lat = 0;
  int cnt = 0;
  logic busy = 1'b0;
  logic [7:0] mem [256];
  logic [7:0] shadow [256];

  always #4 clk = ~clk;

  hostbus_bridge dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_ds_n(rd_ds_n), .wr_rw(wr_rw),
    .ale(ale), .addr_i(addr_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .rdy_oe(rdy_oe), .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_done(reg_done)
  );

  // Register model with per-access latency.
  always @(posedge clk) begin
    if (rst) begin
      reg_done <= 1'b0; busy <= 1'b0; cnt <= 0;
    end else begin
      reg_done <= 1'b0;
      if (reg_req && !busy && !reg_done) begin
        busy <= 1'b1; cnt <= lat;
      end else if (busy) begin
        if (cnt == 0) begin
          busy <= 1'b0; reg_done <= 1'b1;
          if (reg_we) mem[reg_addr] <= reg_wdata;
          else reg_rdata <= mem[reg_addr];
        end else cnt <= cnt - 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_idle(input logic ale_v);
    @(negedge clk);
    cs_n = 1'b1; rd_ds_n = 1'b1; wr_rw = 1'b1; ale = ale_v;
  endtask

  task automatic do_reset(input logic ale_v);
    @(negedge clk);
    rst = 1'b1; cs_n = 1'b1; rd_ds_n = 1'b1; wr_rw = 1'b1; ale = ale_v;
    repeat (3) @(posedge clk);
    #1;
    check(!reg_req && !rdy_oe && !ad_oe, "R1", "outputs in reset",
          {reg_req, rdy_oe, ad_oe}, 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // One host access; style given by moto (data strobe) or separate strobes.
  task automatic run_access(input string tag, input bit moto, input bit we,
                            input logic [1:0] pin_addr, input logic [7:0] exp_addr,
                            input logic [7:0] wdata, input int latency);
    bit bad_wait = 0;
    bit seen_done = 0;
    lat = latency;
    @(negedge clk);
    addr_i = pin_addr;
    ad_i = we ? wdata : 8'hC3;
    cs_n = 1'b0;
    if (moto) begin wr_rw = !we; rd_ds_n = 1'b0; end
    else if (we) wr_rw = 1'b0;
    else rd_ds_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check(!reg_req, "R11", "req before sync delay", reg_req, 0);
    @(posedge clk); #1;
    check(reg_req, "R11", "req on third edge", reg_req, 1);
    check(reg_addr == exp_addr, tag, "reg_addr", reg_addr, exp_addr);
    check(reg_we == we, tag, "reg_we", reg_we, we);
    if (we) check(reg_wdata == wdata, tag, "reg_wdata", reg_wdata, wdata);
    for (int i = 0; i < 40; i++) begin
      if (rdy_oe != !moto) bad_wait = 1;
      if (ad_oe) bad_wait = 1;
      @(posedge clk); #1;
      if (!reg_req) begin seen_done = 1; break; end
    end
    check(seen_done, "R10", "request completes", seen_done, 1);
    check(!bad_wait, moto ? "R8" : "R7", "wait/ack/data level while pending",
          bad_wait, 0);
    check(rdy_oe == moto, moto ? "R8" : "R7", "rdy_oe at completion", rdy_oe, moto);
    if (we) begin
      check(!ad_oe, "R9", "no drive on write", ad_oe, 0);
      shadow[exp_addr] = wdata;
    end else begin
      check(ad_oe && ad_o == shadow[exp_addr], "R9", "read data driven",
            {ad_oe, ad_o}, {1'b1, shadow[exp_addr]});
    end
    repeat (3) @(posedge clk);
    #1;
    check(!reg_req, "R10", "no retrigger while strobe held", reg_req, 0);
    check(rdy_oe == moto, "R8", "ack held with strobe", rdy_oe, moto);
    @(negedge clk);
    cs_n = 1'b1; rd_ds_n = 1'b1; wr_rw = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check(rdy_oe == moto, "R8", "ack until release synced", rdy_oe, moto);
    check(ad_oe == !we, "R9", "data drive until release synced", ad_oe, !we);
    @(posedge clk); #1;
    check(!rdy_oe && !ad_oe, "R8", "released after strobe", {rdy_oe, ad_oe}, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic ale_phase(input logic [7:0] a);
    @(negedge clk);
    ad_i = a; ale = 1'b1;
    repeat (3) @(negedge clk);
    ale = 1'b0;
    repeat (3) @(negedge clk);
    ad_i = 8'h00;
  endtask

  task automatic no_access(input string tag, input logic c, input logic rs,
                           input logic wr);
    bit any = 0;
    @(negedge clk);
    cs_n = c; rd_ds_n = rs; wr_rw = wr;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      if (reg_req || rdy_oe) any = 1;
    end
    check(!any, tag, "no access started", any, 0);
    @(negedge clk);
    cs_n = 1'b1; rd_ds_n = 1'b1; wr_rw = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_sep_direct();
    do_reset(1'b0);
    run_access("R3", 0, 1, 2'd2, 8'd2, 8'hA5, 0);
    run_access("R3", 0, 0, 2'd2, 8'd2, 8'h00, 3);
    run_access("R3", 0, 0, 2'd1, 8'd1, 8'h00, 5);
    no_access("R2", 1'b1, 1'b0, 1'b1);
    no_access("R2", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic test_strobe_dir();
    do_reset(1'b1);
    no_access("R5", 1'b0, 1'b1, 1'b0);
    run_access("R6", 1, 1, 2'd3, 8'd3, 8'h3C, 2);
    run_access("R6", 1, 0, 2'd3, 8'd3, 8'h00, 4);
    run_access("R6", 1, 0, 2'd0, 8'd0, 8'h00, 0);
    no_access("R2", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic test_mux();
    do_reset(1'b0);
    ale_phase(8'h9E);
    run_access("R4", 0, 1, 2'd0, 8'h9E, 8'h77, 1);
    ale_phase(8'h9E);
    run_access("R4", 0, 0, 2'd1, 8'h9E, 8'h00, 6);
    ale_phase(8'h10);
    run_access("R5", 0, 0, 2'd3, 8'h10, 8'h00, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    test_sep_direct();
    test_strobe_dir();
    test_mux();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule